// File: doc/BRIEF.md
# Power-Aware Watchdog Timer

This block is a watchdog for a small controller-class system. It counts machine cycles, marked by a clock-enable strobe, and raises a one-clock reset request when the programmed period runs out. A 3-bit period code sits in an 8-bit select register on a simple register bus. Eight power-of-two periods are available, from 2^BASE_EXP − 1 up to 2^(BASE_EXP+7) − 1 machine cycles. With the default BASE_EXP of 14 and a 12 MHz oscillator, the shortest period is about 16.3 ms.

After reset the watchdog is off. Software arms it by writing a two-byte key to a restart address. Writing the same key again clears the counter and loads the current period code. Once armed, the watchdog stops only when it fires or when the system is reset.

The system controller supplies the power state. In idle the counter keeps running. In power-down the clock is treated as stopped, so the counter holds its value. A wake from power-down by an external level interrupt is signalled with a strobe. After that strobe the counter stays held for as long as the interrupt line is low, so a long oscillator start-up cannot trip the watchdog.

Top module: `wdog_pm`

## Requirements
- R1: The select register is at bus address 0. Only bits [2:0] hold the period code. Writes to bits [7:3] are ignored and reads return 0 there. The code resets to 000. `rd_data` is registered: it shows the register one cycle after `rd_en`, and is 0 after any cycle without a read of address 0.
- R2: After reset the watchdog is disarmed. No reset request is ever issued before it has been armed.
- R3: A write of 0x1E to address 1 followed by a write of 0xE1 as the next write to address 1 arms the watchdog and clears its counter. Any other byte written to address 1 between them aborts the key. Writes to other addresses do not affect the key.
- R4: With code n loaded at the last service, `wdt_rst` goes high in the clock after the (2^(BASE_EXP+n) − 1)-th counted machine cycle since that service.
- R5: `wdt_rst` stays high for exactly one clock. Firing clears the counter and disarms the watchdog, so no further pulse occurs until it is armed again.
- R6: While `pd_mode` is high the counter neither advances nor fires.
- R7: `idle_mode` has no effect on counting. Machine cycles in idle count and can fire the watchdog.
- R8: In the cycle `wake_irq` is high, and afterwards while `irq_n` is low, no cycle counts. The first counted cycle comes after the first clock edge at which `irq_n` is seen high.
- R9: A new period code written while the watchdog is armed is used only from the next service.
- R10: Only clock cycles with `mc_en` high are counted.
- R11: A synchronous reset disarms the watchdog and returns the period code to 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_en | input | 1 | Machine-cycle enable strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (0 = select register, 1 = restart key) |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |
| pd_mode | input | 1 | Power-down active; counting frozen |
| idle_mode | input | 1 | Idle active; counting continues |
| wake_irq | input | 1 | Strobe: power-down ended by a level interrupt |
| irq_n | input | 1 | Level of the wake interrupt pin, active low |
| wdt_rst | output | 1 | One-clock reset request on expiry |

## Verification
The bench builds the block with BASE_EXP = 4, SEL_W = 3, DATA_W = 8 and ADDR_W = 2. That makes the eight periods 15 to 2047 counted cycles, so every period code, including the longest, can expire many times within the run. Directed cases measure exact pulse cycles around power-down, wake hold-off, a period change while armed and an aborted key. A seeded random phase then mixes sparse enables, power episodes and bus traffic against a cycle-level reference model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // State of the restart-key sequencer.
  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_FIRST = 1'b1
  } key_state_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int SEL_W = 3,
  parameter logic [ADDR_W-1:0] SEL_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [SEL_W-1:0]  sel_o
);
  localparam int PAD_W = DATA_W - SEL_W;

  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] rd_q;
  logic              sel_wr;
  logic              unused_hi;

  assign sel_wr    = wr_en && (wr_addr == SEL_ADDR);
  assign unused_hi = ^wr_data[DATA_W-1:SEL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (sel_wr) begin
      sel_q <= wr_data[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_en && (rd_addr == SEL_ADDR)) begin
      rd_q <= {{PAD_W{1'b0}}, sel_q};
    end else begin
      rd_q <= '0;
    end
  end

  assign rd_data = rd_q;
  assign sel_o   = sel_q;

  // R1: a write to the select address lands in the code field
  p_sel_write_r1: assert property (@(posedge clk) disable iff (rst)
    sel_wr |=> (sel_q == $past(wr_data[SEL_W-1:0])));
  // R1: without a write the code holds
  p_sel_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !sel_wr |=> $stable(sel_q));
endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 1,
  parameter logic [DATA_W-1:0] KEY_A = 8'h1E,
  parameter logic [DATA_W-1:0] KEY_B = 8'hE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              service_o
);
  import wdog_pkg::*;

  key_state_e st_q;
  logic       key_wr;

  assign key_wr    = wr_en && (wr_addr == KEY_ADDR);
  assign service_o = key_wr && (st_q == KEY_FIRST) && (wr_data == KEY_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= KEY_IDLE;
    end else if (key_wr) begin
      st_q <= (wr_data == KEY_A) ? KEY_FIRST : KEY_IDLE;
    end
  end

  // R3: a write to another address leaves the key progress alone
  p_key_other_addr_r3: assert property (@(posedge clk) disable iff (rst)
    !key_wr |=> $stable(st_q));
  // R3: a completed key always returns the sequencer to its start state
  p_key_restart_r3: assert property (@(posedge clk) disable iff (rst)
    service_o |=> (st_q == KEY_IDLE));
endmodule

// File: rtl/wdog_gate.sv
module wdog_gate (
  input  logic clk,
  input  logic rst,
  input  logic pd_mode,
  input  logic idle_mode,
  input  logic wake_irq,
  input  logic irq_n,
  output logic stall_o
);
  logic hold_q;
  logic unused_idle;

  // Idle does not stop the clock source, so it takes no part in gating.
  assign unused_idle = idle_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
    end else begin
      hold_q <= (hold_q || wake_irq) && !irq_n;
    end
  end

  assign stall_o = pd_mode || wake_irq || hold_q;

  // R8: once armed by a wake, the hold persists while the pin stays low
  p_hold_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (wake_irq && !irq_n) |=> stall_o || hold_q);
  // R8: a high pin releases the hold by the next edge
  p_hold_release_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_n && !wake_irq) |=> !hold_q);
  // R7: idle alone never stalls the counter
  p_idle_runs_r7: assert property (@(posedge clk) disable iff (rst)
    (idle_mode && !pd_mode && !wake_irq && !hold_q) |-> !stall_o);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int SEL_W = 3,
  parameter int BASE_EXP = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mc_en,
  input  logic             stall,
  input  logic             service,
  input  logic [SEL_W-1:0] sel,
  output logic             bark_o
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int CNT_W = BASE_EXP + NSEL - 1;

  logic [CNT_W-1:0] tc_tab [NSEL];
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] act_sel_q;
  logic             armed_q;
  logic             bark_q;
  logic             tick;
  logic             at_tc;

  // Terminal count per code: the (2^(BASE_EXP+g) - 1)-th tick fires.
  for (genvar g = 0; g < NSEL; g++) begin : g_tc
    assign tc_tab[g] = (CNT_W'(1) << (BASE_EXP + g)) - CNT_W'(2);
  end

  assign tick  = mc_en && armed_q && !stall;
  assign at_tc = (cnt_q == tc_tab[act_sel_q]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      act_sel_q <= '0;
      armed_q   <= 1'b0;
      bark_q    <= 1'b0;
    end else begin
      bark_q <= 1'b0;
      if (service) begin
        cnt_q     <= '0;
        act_sel_q <= sel;
        armed_q   <= 1'b1;
      end else if (tick) begin
        if (at_tc) begin
          cnt_q   <= '0;
          armed_q <= 1'b0;
          bark_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign bark_o = bark_q;

  // R3: a service leaves the counter cleared and armed
  p_svc_clear_r3: assert property (@(posedge clk) disable iff (rst)
    service |=> (cnt_q == '0) && armed_q);
  // R6 / R8: a stalled cycle neither advances nor fires
  p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    (stall && !service) |=> $stable(cnt_q) && !bark_q);
  // R10: cycles without the enable do not count
  p_no_tick_r10: assert property (@(posedge clk) disable iff (rst)
    (!mc_en && !service) |=> $stable(cnt_q) && !bark_q);
  // R5: the request lasts one clock
  p_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    bark_q |=> !bark_q);
  // R5: firing disarms
  p_disarm_r5: assert property (@(posedge clk) disable iff (rst)
    bark_q |-> !armed_q);
  // R2: only an armed watchdog fires
  p_armed_only_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(bark_q) |-> $past(armed_q));
  // R9: the active code changes only on a service
  p_sel_latched_r9: assert property (@(posedge clk) disable iff (rst)
    !service |=> $stable(act_sel_q));
endmodule

// File: rtl/wdog_pm.sv
module wdog_pm #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int SEL_W = 3,
  parameter int BASE_EXP = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mc_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pd_mode,
  input  logic              idle_mode,
  input  logic              wake_irq,
  input  logic              irq_n,
  output logic              wdt_rst
);
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'(1);

  logic [SEL_W-1:0] sel;
  logic             service;
  logic             stall;

  wdog_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .SEL_ADDR(SEL_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .sel_o(sel)
  );

  wdog_key_seq #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR),
    .KEY_A(DATA_W'(8'h1E)), .KEY_B(DATA_W'(8'hE1))
  ) u_key (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .service_o(service)
  );

  wdog_gate u_gate (
    .clk(clk), .rst(rst), .pd_mode(pd_mode), .idle_mode(idle_mode),
    .wake_irq(wake_irq), .irq_n(irq_n), .stall_o(stall)
  );

  wdog_counter #(
    .SEL_W(SEL_W), .BASE_EXP(BASE_EXP)
  ) u_cnt (
    .clk(clk), .rst(rst), .mc_en(mc_en), .stall(stall), .service(service),
    .sel(sel), .bark_o(wdt_rst)
  );

  // R11: reset leaves no request behind
  p_reset_quiet_r11: assert property (@(posedge clk)
    $past(rst) |-> !wdt_rst);
endmodule

// File: tb/wdog_pm_test.sv
`timescale 1ns/1ps
module wdog_pm_test;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam int SW = 3;
  localparam int BE = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mc_en = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          pd_mode = 1'b0;
  logic          idle_mode = 1'b0;
  logic          wake_irq = 1'b0;
  logic          irq_n = 1'b1;
  logic          wdt_rst;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_pm #(.DATA_W(DW), .ADDR_W(AW), .SEL_W(SW), .BASE_EXP(BE)) uut (
    .clk(clk), .rst(rst), .mc_en(mc_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pd_mode(pd_mode), .idle_mode(idle_mode), .wake_irq(wake_irq),
    .irq_n(irq_n), .wdt_rst(wdt_rst)
  );

  function automatic int period(input int code);
    return (1 << (BE + code)) - 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model, advanced on each edge from the inputs driven at negedge.
  bit      m_arm, m_seq, m_hold, m_pulse;
  int      m_cnt, m_lim, m_sel;
  int      m_rd;
  always @(posedge clk) begin
    bit svc, stall;
    int rd_next;
    if (rst) begin
      m_arm = 0; m_seq = 0; m_hold = 0; m_pulse = 0;
      m_cnt = 0; m_lim = period(0); m_sel = 0; m_rd = 0;
    end else begin
      rd_next = (rd_en && rd_addr == 0) ? m_sel : 0;
      m_pulse = 0;
      svc = wr_en && wr_addr == 1 && m_seq && wr_data == 8'hE1;
      if (wr_en && wr_addr == 1) m_seq = (wr_data == 8'h1E);
      stall = pd_mode || m_hold || wake_irq;
      if (svc) begin
        m_arm = 1; m_cnt = 0; m_lim = period(m_sel);
      end else if (m_arm && mc_en && !stall) begin
        m_cnt++;
        if (m_cnt == m_lim) begin
          m_pulse = 1; m_arm = 0; m_cnt = 0;
        end
      end
      m_hold = (m_hold || wake_irq) && !irq_n;
      if (wr_en && wr_addr == 0) m_sel = int'(wr_data[SW-1:0]);
      m_rd = rd_next;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R4 pulse vs model", int'(wdt_rst), int'(m_pulse));
      chk("R1 read vs model", int'(rd_data), m_rd);
    end
  end

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic arm();
    wr(1, 8'h1E);
    wr(1, 8'hE1);
  endtask

  task automatic quiet(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wdt_rst) seen++;
    end
    chk(tag, seen, 0);
  endtask

  task automatic wait_pulse(input int max, output int n);
    n = 0;
    for (int i = 1; i <= max; i++) begin
      @(negedge clk);
      if (wdt_rst) begin n = i; break; end
    end
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5EED_2024));
    repeat (2) @(negedge clk);
    chk("R11 reset wdt_rst", int'(wdt_rst), 0);
    chk("R11 reset rd_data", int'(rd_data), 0);
    do_reset();

    // R1: reset code, reserved bits, registered read
    rd_en = 1; rd_addr = 0; @(negedge clk); rd_en = 0;
    chk("R1 reset code", int'(rd_data), 0);
    wr(0, 8'hFD);
    rd_en = 1; @(negedge clk); rd_en = 0;
    chk("R1 reserved bits read 0", int'(rd_data), 5);
    @(negedge clk);
    chk("R1 no read gives 0", int'(rd_data), 0);

    // R2: never armed, never fires
    wr(0, 0);
    quiet(3000, "R2 unarmed quiet");

    // R4, R10, R5: code 0 period with full enable
    arm(); wait_pulse(100, n); chk("R4 code0 period", n, 15);
    @(negedge clk); chk("R5 single-cycle pulse", int'(wdt_rst), 0);
    quiet(200, "R5 disarmed after firing");

    wr(0, 2); arm(); wait_pulse(200, n); chk("R4 code2 period", n, 63);

    // R3: aborted key, then valid key with stray write elsewhere
    wr(0, 0);
    wr(1, 8'h1E); wr(1, 8'h55); wr(1, 8'hE1);
    quiet(100, "R3 aborted key");
    wr(1, 8'h1E); wr(2, 8'h77); wr(1, 8'hE1);
    wait_pulse(100, n); chk("R3 key across other address", n, 15);

    // R10: enable every third cycle
    begin
      int ticks = 0;
      arm();
      for (int i = 0; i < 200; i++) begin
        mc_en = (i % 3 == 0);
        @(negedge clk);
        if (mc_en) ticks++;
        if (wdt_rst) break;
      end
      mc_en = 1;
      chk("R10 counted enables", ticks, 15);
    end

    // R7: idle keeps counting
    idle_mode = 1; arm(); wait_pulse(100, n); chk("R7 idle period", n, 15);
    idle_mode = 0;

    // R6: power-down freezes
    arm(); repeat (5) @(negedge clk);
    pd_mode = 1; quiet(200, "R6 no fire in power-down");
    pd_mode = 0; wait_pulse(100, n); chk("R6 remaining ticks", n, 10);

    // R8: wake by interrupt, held while pin low
    arm(); repeat (5) @(negedge clk);
    pd_mode = 1; repeat (50) @(negedge clk);
    pd_mode = 0; wake_irq = 1; irq_n = 0; @(negedge clk); wake_irq = 0;
    quiet(100, "R8 held while pin low");
    irq_n = 1; wait_pulse(100, n); chk("R8 resume after release", n, 11);

    // R9: code change while armed waits for the next service
    arm(); wr(0, 3); wait_pulse(100, n); chk("R9 old code still used", n, 14);
    arm(); wait_pulse(300, n); chk("R9 new code after service", n, 127);

    // R11: reset while armed disarms and clears code
    wr(0, 1); arm(); repeat (5) @(negedge clk);
    do_reset();
    quiet(200, "R11 disarmed by reset");
    rd_en = 1; rd_addr = 0; @(negedge clk); rd_en = 0;
    chk("R11 code cleared", int'(rd_data), 0);

    // Seeded random phase checked against the model
    begin
      int pd_left = 0;
      int hold_left = 0;
      for (int i = 0; i < 60000; i++) begin
        mc_en = ($urandom % 4) != 0;
        idle_mode = ($urandom % 8) == 0;
        wake_irq = 0;
        if (pd_left > 0) begin
          pd_left--;
          if (pd_left == 0) begin
            pd_mode = 0;
            if ($urandom % 2) begin
              wake_irq = 1; irq_n = 0; hold_left = 1 + $urandom % 40;
            end
          end
        end else if (hold_left > 0) begin
          hold_left--;
          if (hold_left == 0) irq_n = 1;
        end else if (($urandom % 300) == 0) begin
          pd_mode = 1; pd_left = 1 + $urandom % 60;
        end
        wr_en = ($urandom % 6) == 0;
        case ($urandom % 5)
          0: begin wr_addr = 0; wr_data = DW'($urandom % 4 + (($urandom % 2) << 6)); end
          1, 2: begin wr_addr = 1; wr_data = 8'h1E; end
          3: begin wr_addr = 1; wr_data = 8'hE1; end
          default: begin wr_addr = AW'($urandom); wr_data = DW'($urandom); end
        endcase
        if (($urandom % 40) == 0) wr_en = 0;
        rd_en = ($urandom % 4) == 0;
        rd_addr = AW'($urandom % 3);
        rst = ($urandom % 5000) == 0;
        @(negedge clk);
      end
      rst = 0; wr_en = 0; rd_en = 0; pd_mode = 0; irq_n = 1; wake_irq = 0;
    end

    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule